// File: doc/BRIEF.md
# Super I/O Configuration Port Controller

This block sits on a byte-wide host I/O bus and exposes a two-address configuration window. The even address (`ioAddr` = 0) is the index port and the odd address (`ioAddr` = 1) is the data port. Software unlocks the window with a two-byte key written to the index port. It then selects a register through the index port and moves data through the data port. Another key byte written to the index port locks the window again.

Indices below 0x30 reach a small global register file held inside the block. That file holds the logical-device number (index 0x07), a soft-reset trigger (index 0x02), a serial-device swap control (index 0x2D, bit 5) and a read-only chip identifier (index 0x20). Indices of 0x30 and above are passed to an external per-device resource block, which returns read data on `devRdData`. The block blocks writes to some logical devices, and for devices 0x00 to 0x03 it blocks writes to the interrupt/DMA range 0x70 to 0x7F. Host accesses are single-cycle strobes. Read data and the device-side write outputs are combinational in the cycle of the access. State changes at the clock edge that ends that cycle.

Top module: `sio_cfg_port`

## Requirements
- R1: After hardware reset the window is locked and the stored index is 0x00. Once unlocked, global register 0x07 reads 0x00, register 0x21 reads 0x15 and register 0x2D reads 0x20.
- R2: While locked, an index write of 0x51 followed by an index write of 0x23 unlocks the window.
- R3: After 0x51 has been written, any access that is not an index write of 0x23 (a read, a data write or another index value) drops the partial key. A later lone 0x23 then does not unlock.
- R4: While locked, every read returns 0xFF, data writes change no global register, and `devWrEn` stays low.
- R5: While unlocked, an index write of 0xBB locks the window and leaves the stored index unchanged. Any other index write stores the byte as the index. An index-port read returns the stored index.
- R6: While unlocked, a data access at an index below 0x30 reads or writes the global register at that index. Index 0x20 always reads the `CHIP_ID` parameter and ignores writes.
- R7: A data write to index 0x02 with bit 0 set pulses `cfgRst` in that cycle. It returns every global register to its reset value, sets the index to 0x00 and locks the window. Index 0x02 always reads 0x00.
- R8: While unlocked, a data write at an index of 0x30 or above raises `devWrEn` for that cycle. `devIdx` carries the index, `devWrData` carries the byte and `devSel` carries the selected device. A data read at such an index returns `devRdData`.
- R9: Data writes at indices of 0x30 or above are ignored (`devWrEn` low) when register 0x07 holds 0x01, 0x02, 0x06, 0x08, 0x09, 0x0A, or any value above 0x0C.
- R10: When register 0x07 holds a value below 0x04, data writes to indices 0x70 through 0x7F are ignored.
- R11: When bit 5 of register 0x2D is set, `devSel` is 0x0B when register 0x07 holds 0x05, and 0x05 when it holds 0x0B. When the bit is clear, `devSel` equals register 0x07.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ioWrEn | input | 1 | Host write strobe, one cycle |
| ioRdEn | input | 1 | Host read strobe, one cycle |
| ioAddr | input | 1 | 0 = index port, 1 = data port |
| ioWrData | input | 8 | Host write byte |
| ioRdData | output | 8 | Host read byte (combinational) |
| devSel | output | 8 | Logical device after swap |
| devIdx | output | 8 | Current register index for the device block |
| devWrEn | output | 1 | Accepted per-device write strobe |
| devWrData | output | 8 | Per-device write byte |
| devRdData | input | 8 | Per-device read byte from the resource block |
| cfgRst | output | 1 | Soft-reset pulse to the device block |

## Verification
The bench builds the block with `CHIP_ID` set to 0x5A. This value differs from every reset value in the global file, so a read at index 0x20 that came from the stored register would be seen. The key bytes keep their defaults. Random index writes therefore land on 0x51, 0x23 and 0xBB often enough to pass through armed, unlocked and re-locked states many times. Random writes to index 0x07 cover blocked devices, the low device range that protects 0x70 to 0x7F, and the swapped serial pair. Random writes to 0x2D switch the swap on and off.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam logic [7:0] IDX_SOFTRST = 8'h02;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_CHIPID  = 8'h20;
  localparam logic [7:0] IDX_SWAP    = 8'h2D;
  localparam int         SWAP_BIT    = 5;
  localparam logic [7:0] DEV_SER_A   = 8'h05;
  localparam logic [7:0] DEV_SER_B   = 8'h0B;
  localparam logic [7:0] DEV_MAX     = 8'h0C;
  localparam logic [7:0] DEV_LOW_LIM = 8'h04;
  localparam logic [3:0] IRQ_NIBBLE  = 4'h7;

  typedef struct packed {
    logic cfgMode;   // window unlocked
    logic globWr;    // data write to a global index
    logic devWrReq;  // data write to a device index (before filtering)
    logic softRst;   // soft reset request
  } cfgStrobes_t;

  function automatic logic [7:0] globResetVal(input int i);
    case (i)
      8'h21:   return 8'h15;
      8'h2D:   return 8'h20;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic isBlockedDev(input logic [7:0] ldn);
    case (ldn)
      8'h01, 8'h02, 8'h06, 8'h08, 8'h09, 8'h0A: return 1'b1;
      default: return (ldn > DEV_MAX);
    endcase
  endfunction

endpackage

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
#(
  parameter int         GLOB_DEPTH = 48,
  parameter logic [7:0] KEY_ARM    = 8'h51,
  parameter logic [7:0] KEY_ENTER  = 8'h23,
  parameter logic [7:0] KEY_EXIT   = 8'hBB
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic        addr,
  input  logic [7:0]  wrData,
  output logic [7:0]  idx,
  output cfgStrobes_t strb
);

  localparam logic [7:0] GLOB_LIMIT = 8'(GLOB_DEPTH);

  typedef enum logic [1:0] {ST_LOCKED, ST_ARMED, ST_OPEN} keyState_t;

  keyState_t state, stateNext;
  logic      idxWr, datWr;

  assign idxWr = wrEn && !addr;
  assign datWr = wrEn && addr;

  always_comb begin
    strb.cfgMode  = (state == ST_OPEN);
    strb.globWr   = strb.cfgMode && datWr && (idx < GLOB_LIMIT);
    strb.devWrReq = strb.cfgMode && datWr && (idx >= GLOB_LIMIT);
    strb.softRst  = strb.globWr && (idx == IDX_SOFTRST) && wrData[0];
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_LOCKED: if (idxWr && wrData == KEY_ARM) stateNext = ST_ARMED;
      ST_ARMED: begin
        if (idxWr && wrData == KEY_ENTER) stateNext = ST_OPEN;
        else if (wrEn || rdEn)            stateNext = ST_LOCKED;
      end
      ST_OPEN: begin
        if (strb.softRst)                      stateNext = ST_LOCKED;
        else if (idxWr && wrData == KEY_EXIT)  stateNext = ST_LOCKED;
      end
      default: stateNext = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_LOCKED;
      idx   <= 8'h00;
    end else begin
      state <= stateNext;
      if (strb.softRst)
        idx <= 8'h00;
      else if (strb.cfgMode && idxWr && wrData != KEY_EXIT)
        idx <= wrData;
    end
  end

endmodule

// File: rtl/sio_cfg_dpath.sv
module sio_cfg_dpath
  import sio_cfg_pkg::*;
#(
  parameter int         GLOB_DEPTH = 48,
  parameter logic [7:0] CHIP_ID    = 8'h40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  cfgStrobes_t strb,
  input  logic        addr,
  input  logic [7:0]  idx,
  input  logic [7:0]  wrData,
  input  logic [7:0]  devRdData,
  output logic [7:0]  rdData,
  output logic [7:0]  devSel,
  output logic [7:0]  devIdx,
  output logic [7:0]  devWrData,
  output logic        devWrEn,
  output logic        cfgRst
);

  localparam int         GIDX_W     = $clog2(GLOB_DEPTH);
  localparam logic [7:0] GLOB_LIMIT = 8'(GLOB_DEPTH);

  logic [7:0] globRegs [GLOB_DEPTH];
  logic [7:0] ldn;
  logic       swapOn, irqGuard, storeOk;

  assign storeOk = (idx != IDX_SOFTRST) && (idx != IDX_CHIPID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < GLOB_DEPTH; i++) globRegs[i] <= globResetVal(i);
    end else if (strb.softRst) begin
      for (int i = 0; i < GLOB_DEPTH; i++) globRegs[i] <= globResetVal(i);
    end else if (strb.globWr && storeOk) begin
      globRegs[idx[GIDX_W-1:0]] <= wrData;
    end
  end

  assign ldn    = globRegs[IDX_LDN[GIDX_W-1:0]];
  assign swapOn = globRegs[IDX_SWAP[GIDX_W-1:0]][SWAP_BIT];

  always_comb begin
    devSel = ldn;
    if (swapOn && ldn == DEV_SER_A)      devSel = DEV_SER_B;
    else if (swapOn && ldn == DEV_SER_B) devSel = DEV_SER_A;
  end

  assign irqGuard  = (ldn < DEV_LOW_LIM) && (idx[7:4] == IRQ_NIBBLE);
  assign devWrEn   = strb.devWrReq && !isBlockedDev(ldn) && !irqGuard;
  assign devIdx    = idx;
  assign devWrData = wrData;
  assign cfgRst    = strb.softRst;

  always_comb begin
    if (!strb.cfgMode)          rdData = 8'hFF;
    else if (!addr)             rdData = idx;
    else if (idx >= GLOB_LIMIT) rdData = devRdData;
    else if (idx == IDX_CHIPID) rdData = CHIP_ID;
    else if (idx == IDX_SOFTRST) rdData = 8'h00;
    else                        rdData = globRegs[idx[GIDX_W-1:0]];
  end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int         GLOB_DEPTH = 48,
  parameter logic [7:0] CHIP_ID    = 8'h40,
  parameter logic [7:0] KEY_ARM    = 8'h51,
  parameter logic [7:0] KEY_ENTER  = 8'h23,
  parameter logic [7:0] KEY_EXIT   = 8'hBB
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ioWrEn,
  input  logic       ioRdEn,
  input  logic       ioAddr,
  input  logic [7:0] ioWrData,
  output logic [7:0] ioRdData,
  output logic [7:0] devSel,
  output logic [7:0] devIdx,
  output logic       devWrEn,
  output logic [7:0] devWrData,
  input  logic [7:0] devRdData,
  output logic       cfgRst
);

  cfgStrobes_t strb;
  logic [7:0]  idx;
  logic        cfgMode;

  assign cfgMode = strb.cfgMode;

  sio_cfg_ctrl #(
    .GLOB_DEPTH(GLOB_DEPTH), .KEY_ARM(KEY_ARM),
    .KEY_ENTER(KEY_ENTER), .KEY_EXIT(KEY_EXIT)
  ) uCtrl (
    .clk(clk), .rst_n(rst_n), .wrEn(ioWrEn), .rdEn(ioRdEn),
    .addr(ioAddr), .wrData(ioWrData), .idx(idx), .strb(strb)
  );

  sio_cfg_dpath #(.GLOB_DEPTH(GLOB_DEPTH), .CHIP_ID(CHIP_ID)) uDpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .addr(ioAddr), .idx(idx),
    .wrData(ioWrData), .devRdData(devRdData), .rdData(ioRdData),
    .devSel(devSel), .devIdx(devIdx), .devWrData(devWrData),
    .devWrEn(devWrEn), .cfgRst(cfgRst)
  );

endmodule

// File: rtl/sio_cfg_checker.sv
module sio_cfg_checker #(
  parameter logic [7:0] KEY_ENTER = 8'h23,
  parameter logic [7:0] KEY_EXIT  = 8'hBB
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfgMode,
  input logic       ioWrEn,
  input logic       ioRdEn,
  input logic       ioAddr,
  input logic [7:0] ioWrData,
  input logic [7:0] ioRdData,
  input logic [7:0] devSel,
  input logic [7:0] devIdx,
  input logic       devWrEn,
  input logic       cfgRst
);

  AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfgMode && ioRdEn) |-> ioRdData == 8'hFF);  // R4

  AST_LOCKED_NO_DEVWR: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgMode |-> !devWrEn);  // R4

  AST_ENTER_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfgMode) |-> $past(ioWrEn && !ioAddr && ioWrData == KEY_ENTER));  // R2

  AST_EXIT_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgMode && ioWrEn && !ioAddr && ioWrData == KEY_EXIT) |=> !cfgMode);  // R5

  AST_SOFTRST_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    cfgRst |=> !cfgMode);  // R7

  AST_BLOCKED_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    devWrEn |-> !(devSel == 8'h01 || devSel == 8'h02 || devSel == 8'h06 ||
                  devSel == 8'h08 || devSel == 8'h09 || devSel == 8'h0A ||
                  devSel > 8'h0C));  // R9

  AST_IRQ_RANGE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (devWrEn && devSel < 8'h04) |-> devIdx[7:4] != 4'h7);  // R10

endmodule

bind sio_cfg_port sio_cfg_checker #(.KEY_ENTER(KEY_ENTER), .KEY_EXIT(KEY_EXIT)) uChk (
  .clk(clk), .rst_n(rst_n), .cfgMode(cfgMode), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn),
  .ioAddr(ioAddr), .ioWrData(ioWrData), .ioRdData(ioRdData), .devSel(devSel),
  .devIdx(devIdx), .devWrEn(devWrEn), .cfgRst(cfgRst)
);

// File: tb/tb_sio_cfg_port.sv
module tb_sio_cfg_port;

  localparam logic [7:0] CHIP = 8'h5A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ioWrEn = 1'b0, ioRdEn = 1'b0, ioAddr = 1'b0;
  logic [7:0] ioWrData = 8'h00;
  logic [7:0] ioRdData, devSel, devIdx, devWrData, devRdData;
  logic       devWrEn, cfgRst;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state: 0 locked, 1 armed, 2 open
  int         mSt;
  logic [7:0] mIdx;
  logic [7:0] mGlob [48];

  always #2.5 clk = ~clk;

  sio_cfg_port #(.CHIP_ID(CHIP)) dut (
    .clk(clk), .rst_n(rst_n), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn), .ioAddr(ioAddr),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .devSel(devSel), .devIdx(devIdx),
    .devWrEn(devWrEn), .devWrData(devWrData), .devRdData(devRdData), .cfgRst(cfgRst)
  );

  function automatic logic [7:0] stub(input logic [7:0] s, input logic [7:0] i);
    return {s[3:0], i[3:0]} ^ 8'h3C;
  endfunction

  assign devRdData = stub(devSel, devIdx);

  function automatic void mReset();
    mSt = 0; mIdx = 8'h00;
    for (int i = 0; i < 48; i++) mGlob[i] = 8'h00;
    mGlob[8'h21] = 8'h15; mGlob[8'h2D] = 8'h20;
  endfunction

  function automatic logic [7:0] expSel();
    logic [7:0] l = mGlob[7];
    if (mGlob[8'h2D][5] && l == 8'h05) return 8'h0B;
    if (mGlob[8'h2D][5] && l == 8'h0B) return 8'h05;
    return l;
  endfunction

  function automatic bit blk(input logic [7:0] l);
    return l == 1 || l == 2 || l == 6 || l == 8 || l == 9 || l == 10 || l > 12;
  endfunction

  function automatic logic [7:0] expRead(input bit a);
    if (mSt != 2) return 8'hFF;
    if (!a) return mIdx;
    if (mIdx >= 8'h30) return stub(expSel(), mIdx);
    if (mIdx == 8'h20) return CHIP;
    if (mIdx == 8'h02) return 8'h00;
    return mGlob[mIdx];
  endfunction

  function automatic bit expDevWr();
    return mSt == 2 && mIdx >= 8'h30 && !blk(mGlob[7]) &&
           !(mGlob[7] < 8'h04 && mIdx[7:4] == 4'h7);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic ioWr(input bit a, input logic [7:0] d, input string req);
    bit eDev, eRst;
    @(negedge clk);
    ioWrEn = 1'b1; ioAddr = a; ioWrData = d;
    eDev = a && expDevWr();
    eRst = a && mSt == 2 && mIdx == 8'h02 && d[0];
    #1;
    chk(devWrEn === eDev, req, {7'b0, devWrEn}, {7'b0, eDev});
    chk(cfgRst === eRst, eRst ? "R7" : req, {7'b0, cfgRst}, {7'b0, eRst});
    if (eDev) begin
      chk(devSel === expSel(), "R8", devSel, expSel());
      chk(devIdx === mIdx && devWrData === d, "R8", devWrData, d);
    end
    @(posedge clk); #0.5;
    ioWrEn = 1'b0;
    case (mSt)
      0: if (!a && d == 8'h51) mSt = 1;
      1: mSt = (!a && d == 8'h23) ? 2 : 0;
      default: begin
        if (!a) begin
          if (d == 8'hBB) mSt = 0; else mIdx = d;
        end else if (mIdx < 8'h30) begin
          if (mIdx == 8'h02) begin
            if (d[0]) mReset();
          end else if (mIdx != 8'h20) mGlob[mIdx] = d;
        end
      end
    endcase
  endtask

  task automatic ioRd(input bit a, input string req);
    logic [7:0] e;
    @(negedge clk);
    ioRdEn = 1'b1; ioAddr = a;
    e = expRead(a);
    #1;
    chk(ioRdData === e, req, ioRdData, e);
    @(posedge clk); #0.5;
    ioRdEn = 1'b0;
    if (mSt == 1) mSt = 0;
  endtask

  task automatic sel(input logic [7:0] i, input logic [7:0] v);
    ioWr(0, i, "R5"); ioWr(1, v, "R6");
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=00 expected=01");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mReset();
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;

    // R1 / R4: locked after reset
    ioRd(0, "R1");
    ioRd(1, "R4");
    ioWr(1, 8'h77, "R4");
    // R2: key entry
    ioWr(0, 8'h51, "R2"); ioWr(0, 8'h23, "R2");
    ioRd(0, "R1");
    ioWr(0, 8'h21, "R5"); ioRd(1, "R1");
    ioWr(0, 8'h2D, "R5"); ioRd(1, "R1");
    ioWr(0, 8'h07, "R5"); ioRd(1, "R1");
    // R6: chip id read-only
    ioWr(0, 8'h20, "R5"); ioRd(1, "R6");
    ioWr(1, 8'h99, "R6"); ioRd(1, "R6");
    ioWr(0, 8'h11, "R5"); ioWr(1, 8'hC3, "R6"); ioRd(1, "R6");
    // R5: exit keeps index
    ioWr(0, 8'hBB, "R5"); ioRd(0, "R5");
    // R3: broken keys
    ioWr(0, 8'h51, "R3"); ioRd(0, "R3"); ioWr(0, 8'h23, "R3"); ioRd(0, "R3");
    ioWr(0, 8'h51, "R3"); ioWr(1, 8'h00, "R3"); ioWr(0, 8'h23, "R3"); ioRd(0, "R3");
    ioWr(0, 8'h51, "R3"); ioWr(0, 8'h51, "R3"); ioWr(0, 8'h23, "R3"); ioRd(0, "R3");
    ioWr(0, 8'h51, "R2"); ioWr(0, 8'h23, "R2"); ioRd(0, "R5");
    // R10 / R8: low device IRQ range
    sel(8'h07, 8'h03);
    ioWr(0, 8'h70, "R10"); ioWr(1, 8'h0E, "R10");
    ioWr(0, 8'h7F, "R10"); ioWr(1, 8'h0E, "R10");
    ioWr(0, 8'h60, "R8"); ioWr(1, 8'h03, "R8"); ioRd(1, "R8");
    sel(8'h07, 8'h04); ioWr(0, 8'h70, "R10"); ioWr(1, 8'h04, "R10");
    // R9: blocked devices
    sel(8'h07, 8'h09); ioWr(0, 8'h30, "R9"); ioWr(1, 8'h01, "R9");
    sel(8'h07, 8'h0D); ioWr(0, 8'h30, "R9"); ioWr(1, 8'h01, "R9");
    sel(8'h07, 8'h0C); ioWr(0, 8'hF0, "R9"); ioWr(1, 8'h01, "R9");
    // R11: swap
    sel(8'h07, 8'h05); ioWr(0, 8'hF0, "R11"); ioWr(1, 8'h12, "R11"); ioRd(1, "R11");
    sel(8'h2D, 8'h00); sel(8'h07, 8'h05); ioWr(0, 8'hF0, "R11"); ioWr(1, 8'h12, "R11");
    sel(8'h07, 8'h0B); ioWr(0, 8'h61, "R11"); ioWr(1, 8'h34, "R11"); ioRd(1, "R11");
    // R7: soft reset
    ioWr(0, 8'h02, "R7"); ioWr(1, 8'h00, "R7"); ioRd(1, "R7");
    ioWr(1, 8'h01, "R7"); ioRd(0, "R7");
    ioWr(0, 8'h51, "R7"); ioWr(0, 8'h23, "R7"); ioRd(0, "R7");
    ioWr(0, 8'h2D, "R7"); ioRd(1, "R7");

    // random phase
    for (int n = 0; n < 1500; n++) begin
      int    k = $urandom_range(0, 9);
      logic [7:0] v;
      case ($urandom_range(0, 11))
        0: v = 8'h51;  1: v = 8'h23;  2: v = 8'hBB;  3: v = 8'h07;
        4: v = 8'h2D;  5: v = 8'h02;  6: v = 8'h70;  7: v = 8'h75;
        8: v = 8'hF0;  9: v = 8'h20;  default: v = 8'($urandom);
      endcase
      if (k < 4)      ioWr(0, v, mSt == 2 ? "R5" : "R2");
      else if (k < 7) ioWr(1, ($urandom_range(0, 1) != 0) ? 8'($urandom_range(0, 14)) : 8'($urandom),
                           mSt != 2 ? "R4" : (mIdx >= 8'h30 ? "R8" : "R6"));
      else            ioRd(($urandom_range(0, 2) != 0), mSt != 2 ? "R4" : "R6");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule